// File: doc/BRIEF.md
# Randomized Stall Padding Unit

This block sits beside a block cipher engine and decides, for every block the engine starts, how many idle cycles to add to that operation. The idle cycles blur the link between the processed data and the operation's timing and power draw. Four enable bits switch the padding sources on or off one by one. Two sources each add zero or one cycle. A third adds a bounded random run whose upper limit grows with the key length. The fourth drives a toggling noise vector while padding is in progress.

All randomness comes from a deterministic 32-bit generator loaded through a seed port. Padding stays off after reset until the first seed arrives. It turns off again whenever the key-size code changes, and stays off until the next seed. While padding is off, every block start returns a zero-length stall and an immediate done pulse. The engine waits for the done pulse before it continues.

Top module: `stall_pad_top`

## Requirements
- R1: After reset the enable field reads as binary 1111 in effect, stallCount is 0, stallBusy, stallDone and noiseVec are 0, and no seed counts as written.
- R2: While no valid seed is held, an accepted blockStart gives stallCount 0 and a stallDone pulse in the cycle just after the accepting edge.
- R3: A seed write loads the 32-bit generator with seedData, or with 32'h1D872B41 when seedData is zero, and marks the seed valid. Each accepted blockStart advances the generator once, whether or not the seed is valid, to {g[30:0], g[31]^g[21]^g[1]^g[0]}.
- R4: With a valid seed, enable bit 0 adds generator bit 0 to the stall and enable bit 1 adds generator bit 1. Both are read from the generator value held before the advance.
- R5: With a valid seed, enable bit 2 adds generator bits [15:8] modulo (cap+1). The cap is 11 for key code 0, 13 for key code 1 and 15 for key codes 2 and 3. The total stall therefore never exceeds cap+2.
- R6: An accepted blockStart registers the total in stallCount. stallBusy is then high for exactly that many cycles, and stallDone is high for one cycle right after the last busy cycle.
- R7: A blockStart that arrives while stallBusy is high is ignored. stallCount stays unchanged and the generator does not advance.
- R8: Any change of keySize from its value in the previous cycle clears seed validity, and this takes priority over a seed write in the same cycle. Padding stays zero until the next seed write.
- R9: noiseVec equals a 16-bit noise register while stallBusy is high, enable bit 3 is set and the seed is valid. Otherwise noiseVec is 0. A seed write loads the noise register with seedData[15:0], or with 1 when those bits are zero. The register steps as {s[14:0], s[15]^s[13]^s[12]^s[10]} on every busy cycle.
- R10: A cfgWrite replaces the enable field with cfgEnable. Bit 0 and bit 1 control the single-cycle sources, bit 2 the bounded run and bit 3 the noise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrite | input | 1 | Load the enable field |
| cfgEnable | input | 4 | New enable field value |
| seedWrite | input | 1 | Load the seed |
| seedData | input | 32 | Seed value |
| keySize | input | 2 | Key length code (0, 1, 2/3) |
| blockStart | input | 1 | One cipher block starts |
| stallCount | output | 5 | Padding length chosen for the latest accepted start |
| stallBusy | output | 1 | Padding cycles still remaining |
| stallDone | output | 1 | One-cycle pulse when the padding has elapsed |
| noiseVec | output | 16 | Spurious activity vector |

## Verification
The hardest case to reach from the ports is the loss of seed validity caused by a key-size change. A key change gives no visible output of its own. It only appears as zero padding on later block starts, and even a valid seed gives zero padding for some generator values. The stimulus therefore first confirms non-zero padding with a known seed. It then changes the key code and issues several starts, which must all return zero. Before it reseeds, it also tries a key change and a seed write in the same cycle. A long stall is found by having the bench model predict the totals and skip ahead until a long one is due. The bench then holds blockStart high through the whole busy window to show that those starts are ignored.

// File: rtl/stall_pad_pkg.sv
package stall_pad_pkg;
  localparam int SEED_W  = 32;
  localparam int NOISE_W = 16;
  localparam int EN_W    = 4;
  localparam int KEY_W   = 2;
  localparam int SLICE_LO = 8;
  localparam int SLICE_W  = 8;
  localparam int CAP_K0 = 11;
  localparam int CAP_K1 = 13;
  localparam int CAP_K2 = 15;
  localparam int MAX_TOTAL = CAP_K2 + 2;
  localparam int CNT_W = $clog2(MAX_TOTAL + 1);
  localparam logic [SEED_W-1:0] SEED_FALLBACK = 32'h1D87_2B41;
  localparam logic [NOISE_W-1:0] NOISE_FALLBACK = 16'h0001;

  typedef struct packed {
    logic loadSeed;
    logic accept;
    logic padOn;
  } padStrobe_t;

  function automatic logic [CNT_W-1:0] capOf(input logic [KEY_W-1:0] k);
    case (k)
      2'd0:    capOf = CNT_W'(CAP_K0);
      2'd1:    capOf = CNT_W'(CAP_K1);
      default: capOf = CNT_W'(CAP_K2);
    endcase
  endfunction
endpackage

// File: rtl/stall_pad_ctrl.sv
module stall_pad_ctrl
  import stall_pad_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrite,
  input  logic [EN_W-1:0]  cfgEnable,
  input  logic             seedWrite,
  input  logic [KEY_W-1:0] keySize,
  input  logic             blockStart,
  input  logic             busy,
  output logic [EN_W-1:0]  enables,
  output padStrobe_t       strobe
);
  logic [KEY_W-1:0] keyPrev;
  logic             seedValid;
  logic             keyChange;

  assign keyChange = (keySize != keyPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enables   <= '1;
      keyPrev   <= '0;
      seedValid <= 1'b0;
    end else begin
      keyPrev <= keySize;
      if (cfgWrite) enables <= cfgEnable;
      if (keyChange)      seedValid <= 1'b0;
      else if (seedWrite) seedValid <= 1'b1;
    end
  end

  always_comb begin
    strobe.loadSeed = seedWrite;
    strobe.accept   = blockStart && !busy;
    strobe.padOn    = seedValid;
  end
endmodule

// File: rtl/stall_pad_datapath.sv
module stall_pad_datapath
  import stall_pad_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  padStrobe_t        strobe,
  input  logic [EN_W-1:0]   enables,
  input  logic [KEY_W-1:0]  keySize,
  input  logic [SEED_W-1:0] seedData,
  output logic [CNT_W-1:0]  stallCount,
  output logic              busy,
  output logic              done,
  output logic [NOISE_W-1:0] noiseVec
);
  logic [SEED_W-1:0]  genState;
  logic [SEED_W-1:0]  genNext;
  logic [NOISE_W-1:0] noiseState;
  logic [NOISE_W-1:0] noiseNext;
  logic [CNT_W-1:0]   remain;
  logic [CNT_W-1:0]   total;
  logic [CNT_W-1:0]   runLen;
  logic [SLICE_W-1:0] slice;
  logic [SLICE_W-1:0] modBase;
  logic [SLICE_W-1:0] modOut;
  logic               bit1Add;
  logic               bit2Add;

  assign genNext   = {genState[SEED_W-2:0],
                      genState[31] ^ genState[21] ^ genState[1] ^ genState[0]};
  assign noiseNext = {noiseState[NOISE_W-2:0],
                      noiseState[15] ^ noiseState[13] ^ noiseState[12] ^ noiseState[10]};

  assign slice   = genState[SLICE_LO +: SLICE_W];
  assign modBase = SLICE_W'(capOf(keySize)) + SLICE_W'(1);
  assign modOut  = slice % modBase;

  always_comb begin
    bit1Add = strobe.padOn && enables[0] && genState[0];
    bit2Add = strobe.padOn && enables[1] && genState[1];
    runLen  = (strobe.padOn && enables[2]) ? CNT_W'(modOut) : '0;
    total   = CNT_W'(bit1Add) + CNT_W'(bit2Add) + runLen;
  end

  assign busy     = (remain != '0);
  assign noiseVec = (busy && enables[3] && strobe.padOn) ? noiseState : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genState   <= SEED_FALLBACK;
      noiseState <= NOISE_FALLBACK;
      remain     <= '0;
      stallCount <= '0;
      done       <= 1'b0;
    end else begin
      if (strobe.loadSeed) begin
        genState   <= (seedData == '0) ? SEED_FALLBACK : seedData;
        noiseState <= (seedData[NOISE_W-1:0] == '0) ? NOISE_FALLBACK
                                                     : seedData[NOISE_W-1:0];
      end else begin
        if (strobe.accept) genState <= genNext;
        if (busy)          noiseState <= noiseNext;
      end

      if (strobe.accept) begin
        remain     <= total;
        stallCount <= total;
        done       <= (total == '0);
      end else if (busy) begin
        remain <= remain - CNT_W'(1);
        done   <= (remain == CNT_W'(1));
      end else begin
        done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stall_pad_top.sv
module stall_pad_top
  import stall_pad_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrite,
  input  logic [3:0]  cfgEnable,
  input  logic        seedWrite,
  input  logic [31:0] seedData,
  input  logic [1:0]  keySize,
  input  logic        blockStart,
  output logic [4:0]  stallCount,
  output logic        stallBusy,
  output logic        stallDone,
  output logic [15:0] noiseVec
);
  padStrobe_t      strobe;
  logic [EN_W-1:0] enables;

  stall_pad_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgEnable(cfgEnable),
    .seedWrite(seedWrite), .keySize(keySize), .blockStart(blockStart),
    .busy(stallBusy), .enables(enables), .strobe(strobe)
  );

  stall_pad_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .enables(enables),
    .keySize(keySize), .seedData(seedData), .stallCount(stallCount),
    .busy(stallBusy), .done(stallDone), .noiseVec(noiseVec)
  );
endmodule

// File: rtl/stall_pad_checker.sv
module stall_pad_checker (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  keySize,
  input logic        blockStart,
  input logic [4:0]  stallCount,
  input logic        stallBusy,
  input logic        stallDone,
  input logic [15:0] noiseVec
);
  p_count_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (blockStart && !stallBusy) |=>
      (stallCount <= (($past(keySize) == 2'd0) ? 5'd13 :
                      ($past(keySize) == 2'd1) ? 5'd15 : 5'd17)));

  p_noise_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stallBusy |-> (noiseVec == 16'h0));

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    stallDone |-> !stallBusy);

  p_busy_ignores_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stallBusy && blockStart) |=> $stable(stallCount));

  p_busy_ends_with_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stallBusy && !blockStart) |=> (stallBusy || stallDone));
endmodule

bind stall_pad_top stall_pad_checker u_chk (
  .clk(clk), .rstN(rstN), .keySize(keySize), .blockStart(blockStart),
  .stallCount(stallCount), .stallBusy(stallBusy), .stallDone(stallDone),
  .noiseVec(noiseVec)
);

// File: tb/stall_pad_top_test.sv
module stall_pad_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [3:0]  cfgEnable = 4'h0;
  logic        seedWrite = 1'b0;
  logic [31:0] seedData = 32'h0;
  logic [1:0]  keySize = 2'd0;
  logic        blockStart = 1'b0;
  logic [4:0]  stallCount;
  logic        stallBusy;
  logic        stallDone;
  logic [15:0] noiseVec;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] mGen;
  logic [15:0] mNoise;
  logic [3:0]  mEn;
  logic        mValid;

  always #4 clk = ~clk;

  stall_pad_top uut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgEnable(cfgEnable),
    .seedWrite(seedWrite), .seedData(seedData), .keySize(keySize),
    .blockStart(blockStart), .stallCount(stallCount), .stallBusy(stallBusy),
    .stallDone(stallDone), .noiseVec(noiseVec)
  );

  function automatic logic [31:0] step32(input logic [31:0] g);
    return {g[30:0], g[31] ^ g[21] ^ g[1] ^ g[0]};
  endfunction

  function automatic logic [15:0] step16(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic int capFor(input logic [1:0] k);
    return (k == 2'd0) ? 11 : (k == 2'd1) ? 13 : 15;
  endfunction

  function automatic int expTotal(input logic [31:0] g, input logic [3:0] en,
                                  input logic v, input logic [1:0] k);
    int t;
    if (!v) return 0;
    t = 0;
    if (en[0]) t += int'(g[0]);
    if (en[1]) t += int'(g[1]);
    if (en[2]) t += int'(g[15:8]) % (capFor(k) + 1);
    return t;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeSeed(input logic [31:0] v);
    @(negedge clk);
    seedWrite = 1'b1; seedData = v;
    @(negedge clk);
    seedWrite = 1'b0;
    mGen   = (v == 32'h0) ? 32'h1D872B41 : v;
    mNoise = (v[15:0] == 16'h0) ? 16'h0001 : v[15:0];
    mValid = 1'b1;
  endtask

  task automatic writeEn(input logic [3:0] v);
    @(negedge clk);
    cfgWrite = 1'b1; cfgEnable = v;
    @(negedge clk);
    cfgWrite = 1'b0;
    mEn = v;
  endtask

  task automatic changeKey(input logic [1:0] k);
    @(negedge clk);
    if (k != keySize) mValid = 1'b0;
    keySize = k;
    @(negedge clk);
  endtask

  // one accepted start; holdBusy keeps blockStart high during the busy window
  task automatic doStart(input bit holdBusy, output int expT);
    int e;
    e = expTotal(mGen, mEn, mValid, keySize);
    expT = e;
    @(negedge clk);
    blockStart = 1'b1;
    @(negedge clk);
    if (!(holdBusy && e > 0)) blockStart = 1'b0;
    mGen = step32(mGen);
    check("R6 stallCount", int'(stallCount), e);
    for (int j = 0; j <= e; j++) begin
      if (j > 0) @(negedge clk);
      if (j == e) blockStart = 1'b0;
      check("R6 busy", int'(stallBusy), (j < e) ? 1 : 0);
      check("R6 done", int'(stallDone), (j == e) ? 1 : 0);
      if (holdBusy) check("R7 count held", int'(stallCount), e);
      check("R9 noise", int'(noiseVec),
            (j < e && mEn[3] && mValid) ? int'(mNoise) : 0);
      if (j < e) mNoise = step16(mNoise);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t;
    int seen;
    logic [31:0] rv;
    void'($urandom(32'd7321));
    mGen = 32'h1D872B41; mNoise = 16'h0001; mEn = 4'hF; mValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", int'(stallCount), 0);
    check("R1 busy", int'(stallBusy), 0);
    check("R1 done", int'(stallDone), 0);
    check("R1 noise", int'(noiseVec), 0);

    // R2 no seed: zero padding, generator still advances (R3)
    doStart(1'b0, t);
    check("R2 zero without seed", t, 0);
    doStart(1'b0, t);

    // R3 zero seed uses fallback constant; R4/R5/R10 via model
    writeSeed(32'h0);
    for (int i = 0; i < 4; i++) doStart(1'b0, t);
    writeSeed(32'hA5C3_F00F);
    writeEn(4'b0001);
    for (int i = 0; i < 4; i++) doStart(1'b0, t);
    writeEn(4'b0010);
    for (int i = 0; i < 4; i++) doStart(1'b0, t);
    writeEn(4'b1100);
    for (int i = 0; i < 4; i++) begin
      doStart(1'b0, t);
      check("R5 cap bound", (t <= capFor(keySize) + 2) ? 1 : 0, 1);
    end

    // R7 long stall with blockStart held high
    writeEn(4'hF);
    seen = 0;
    for (int i = 0; i < 40 && seen == 0; i++) begin
      if (expTotal(mGen, mEn, mValid, keySize) >= 3) begin
        doStart(1'b1, t);
        seen = 1;
      end else doStart(1'b0, t);
    end
    check("R7 long stall reached", seen, 1);
    doStart(1'b0, t);

    // R8 key change invalidates seed
    seen = 0;
    for (int i = 0; i < 20 && seen == 0; i++) begin
      doStart(1'b0, t);
      if (t > 0) seen = 1;
    end
    check("R8 padding active before change", seen, 1);
    changeKey(2'd2);
    for (int i = 0; i < 4; i++) begin
      doStart(1'b0, t);
      check("R8 zero after key change", t, 0);
    end
    // key change and seed write in the same cycle: key change wins
    @(negedge clk);
    keySize = 2'd1; seedWrite = 1'b1; seedData = 32'h1234_5678;
    @(negedge clk);
    seedWrite = 1'b0;
    mGen = 32'h1234_5678; mNoise = 16'h5678; mValid = 1'b0;
    for (int i = 0; i < 3; i++) doStart(1'b0, t);
    writeSeed(32'h0F0F_3C3C);
    for (int i = 0; i < 4; i++) doStart(1'b0, t);

    // constrained random mix
    for (int i = 0; i < 60; i++) begin
      case ($urandom % 6)
        0: begin rv = $urandom; if (($urandom % 8) == 0) rv = 32'h0; writeSeed(rv); end
        1: writeEn(4'($urandom));
        2: changeKey(2'($urandom));
        default: doStart(($urandom % 4) == 0, t);
      endcase
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule